// File: doc/BRIEF.md
# Dual-Channel Serial Pattern Controller

This block plays back short bit patterns on two output channels. Each channel has a clock line and a data line. Software programs the pattern through a simple register port: a pattern of up to 64 bits, a pattern length, a repeat count, a clock divider and a clock polarity. Setting the channel's enable bit then starts playback. The data line shifts out one pattern bit per generated clock period, starting at the least significant bit of the low data word. The whole pattern is repeated the programmed number of times. The channel then parks, and its completion is raised as an interrupt.

The two channels are independent, but a single control write can enable both. In that case they start on the same I/O clock cycle and act as one four-wire pattern. A channel runs on a private copy of its settings. That copy follows the software registers only while the channel is disabled. Reprogramming a running channel therefore has no effect until the channel has been disabled and enabled again. The interrupt state bits are cleared by writing one to them, and each output is masked by an enable register.

Top module: `dual_pattern_ctrl`

## Requirements
- R1: After reset every register reads zero, and all clock, data and interrupt outputs are low.
- R2: A channel starts with pattern bit 0 on its data line in the second cycle after the write that sets its enable bit. Its data line is 0 in the first cycle. Clearing the enable bit halts the channel. From the second cycle after that write, the data line is 0 and the clock line is at its idle level. A halted channel never reports completion.
- R3: The clock line idles at the polarity bit's value. While running, it holds that level for prediv+1 cycles, then the inverted level for prediv+1 cycles, and it repeats.
- R4: Each pattern bit is driven for 2*(prediv+1) cycles. Bit k comes from bit k of the 64-bit word formed as {high data register, low data register}. The low word therefore holds bits 0 to 31, which are sent first.
- R5: A run sends length+1 bits per pass and makes repeats+1 passes. When it ends, the data line drops to 0 and the clock line returns to its idle level.
- R6: While a channel is enabled, writes to its data, size, divider or polarity fields do not change its output. The new values apply after a disable and re-enable.
- R7: One control write that sets both enable bits starts both channels in the same cycle. Their clock edges and bit changes then stay aligned cycle for cycle.
- R8: A channel's interrupt state bit (bit 0 for channel 0, bit 1 for channel 1) is set in the same cycle in which its clock line returns to idle at the end of the run.
- R9: Each interrupt output equals its interrupt state bit ANDed with the matching interrupt enable bit.
- R10: Writing 1 to an interrupt state bit clears it. Writing 0 leaves it unchanged.
- R11: If a completion and a clear of the same state bit fall in the same cycle, the bit is set.
- R12: The register map, byte addressed, is as follows. 0x00 is control: enable ch0 in bit 0, enable ch1 in bit 1, polarity ch0 in bit 2, polarity ch1 in bit 3. 0x04 and 0x08 hold the ch0 and ch1 dividers. 0x0C and 0x10 hold the ch0 low and high data words. 0x14 and 0x18 hold the ch1 low and high data words. 0x1C is size: ch0 length in 5:0, ch0 repeats in 15:6, ch1 length in 21:16, ch1 repeats in 31:22. 0x20 is interrupt state, and 0x24 is interrupt enable. Every register reads back what was last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | I/O clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe, one write per cycle |
| reg_addr_i | input | 6 | Byte address of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| pcl_o | output | 2 | Pattern clock line per channel |
| pda_o | output | 2 | Pattern data line per channel |
| irq_done_o | output | 2 | Completion interrupt per channel |

## Verification
Count t from the I/O clock edge that applies an enabling write. The data line is still 0 one cycle later. The first bit appears two cycles later, and every later clock and data value is due at a cycle computed from prediv, length and repeats. The interrupt state bit rises with the final clock return, one cycle after the last bit period closes. The driver turns each run into one expected value per line per cycle, tagged with the cycle counter value at which it is due. The monitor compares each value on the falling clock edge of exactly that cycle, and any item whose cycle has passed unchecked is reported as a failure. Register reads are combinational and are sampled just after the address is set. The set-versus-clear collision is timed so that the clearing write lands on the computed completion edge.

// File: rtl/patt_pkg.sv
// Package: shared sizes, register addresses and the per-channel settings
// record used by the dual-channel pattern controller.
package patt_pkg;

    localparam int NUM_CH = 2;                // channels
    localparam int DW     = 32;               // register width
    localparam int AW     = 6;                // byte address width
    localparam int DIV_W  = 32;               // divider width
    localparam int LEN_W  = 6;                // pattern length field width
    localparam int REP_W  = 10;               // repeat field width
    localparam int PAT_W  = 1 << LEN_W;       // pattern bits per channel
    localparam int PAT_WORDS = PAT_W / DW;    // data words per channel
    localparam int SIZE_STRIDE = LEN_W + REP_W;

    localparam logic [AW-1:0] A_CTRL     = 6'h00;
    localparam logic [AW-1:0] A_DIV_BASE = 6'h04;
    localparam logic [AW-1:0] A_DAT_BASE = 6'h0C;
    localparam logic [AW-1:0] A_SIZE     = 6'h1C;
    localparam logic [AW-1:0] A_ISTATE   = 6'h20;
    localparam logic [AW-1:0] A_IEN      = 6'h24;

    typedef struct packed {
        logic [DIV_W-1:0] prediv;
        logic [PAT_W-1:0] pattern;
        logic [LEN_W-1:0] len;
        logic [REP_W-1:0] reps;
        logic             pol;
    } chan_cfg_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_END  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/patt_regs.sv
// Module: patt_regs
// Holds the software-visible control, divider, data and size registers and
// maps them onto one settings record per channel. It also returns read data
// for every address, including the interrupt registers kept in patt_irq.
// Assumes at most one access per cycle and word-aligned addresses.
module patt_regs
    import patt_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_i,
    input  logic [AW-1:0]          addr_i,
    input  logic [DW-1:0]          wdata_i,
    input  logic [NUM_CH-1:0]      istate_i,
    input  logic [NUM_CH-1:0]      ien_i,
    output logic [DW-1:0]          rdata_o,
    output logic [NUM_CH-1:0]      en_o,
    output chan_cfg_t [NUM_CH-1:0] cfg_o
);

    localparam int CTRL_W = 2 * NUM_CH;
    localparam int NUM_DAT = PAT_WORDS * NUM_CH;

    logic [CTRL_W-1:0] ctrl_q;
    logic [DW-1:0]     size_q;
    logic [DIV_W-1:0]  div_q [NUM_CH];
    logic [DW-1:0]     dat_q [NUM_DAT];

    // Control register: enables in the low half, polarities in the high half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (we_i && addr_i == A_CTRL) begin
            ctrl_q <= wdata_i[CTRL_W-1:0];
        end
    end

    // Size register: length and repeat fields for every channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= '0;
        end else if (we_i && addr_i == A_SIZE) begin
            size_q <= wdata_i;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_div
        localparam logic [AW-1:0] ADDR = AW'(int'(A_DIV_BASE) + 4 * c);
        // Divider register of channel c.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                div_q[c] <= '0;
            end else if (we_i && addr_i == ADDR) begin
                div_q[c] <= wdata_i;
            end
        end
    end

    for (genvar j = 0; j < NUM_DAT; j++) begin : g_dat
        localparam logic [AW-1:0] ADDR = AW'(int'(A_DAT_BASE) + 4 * j);
        // Data word j: channel j/PAT_WORDS, word j%PAT_WORDS (low word first).
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dat_q[j] <= '0;
            end else if (we_i && addr_i == ADDR) begin
                dat_q[j] <= wdata_i;
            end
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cfg
        logic [PAT_W-1:0] pat;
        for (genvar w = 0; w < PAT_WORDS; w++) begin : g_word
            assign pat[w*DW +: DW] = dat_q[c*PAT_WORDS + w];
        end
        assign cfg_o[c].prediv  = div_q[c];
        assign cfg_o[c].pattern = pat;
        assign cfg_o[c].len     = size_q[c*SIZE_STRIDE +: LEN_W];
        assign cfg_o[c].reps    = size_q[c*SIZE_STRIDE + LEN_W +: REP_W];
        assign cfg_o[c].pol     = ctrl_q[NUM_CH + c];
        assign en_o[c]          = ctrl_q[c];
    end

    // Read multiplexer over all registers.
    always_comb begin
        rdata_o = '0;
        if (addr_i == A_CTRL)   rdata_o = DW'(ctrl_q);
        if (addr_i == A_SIZE)   rdata_o = size_q;
        if (addr_i == A_ISTATE) rdata_o = DW'(istate_i);
        if (addr_i == A_IEN)    rdata_o = DW'(ien_i);
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr_i == AW'(int'(A_DIV_BASE) + 4 * c)) rdata_o = div_q[c];
        end
        for (int j = 0; j < NUM_DAT; j++) begin
            if (addr_i == AW'(int'(A_DAT_BASE) + 4 * j)) rdata_o = dat_q[j];
        end
    end

endmodule

// File: rtl/patt_irq.sv
// Module: patt_irq
// Keeps the per-channel completion state bits (write one to clear) and their
// enable mask, and drives the masked interrupt outputs. A completion in the
// same cycle as a clear leaves the bit set.
// Assumes done_i is a single-cycle pulse per completed run.
module patt_irq
    import patt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [NUM_CH-1:0] wbits_i,
    input  logic [NUM_CH-1:0] done_i,
    output logic [NUM_CH-1:0] state_o,
    output logic [NUM_CH-1:0] en_o,
    output logic [NUM_CH-1:0] irq_o
);

    logic [NUM_CH-1:0] state_q;
    logic [NUM_CH-1:0] en_q;
    logic [NUM_CH-1:0] clr;

    assign clr = (we_i && addr_i == A_ISTATE) ? wbits_i : '0;

    // State bits: clear on a written one, set on completion (set dominates).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= (state_q & ~clr) | done_i;
        end
    end

    // Interrupt enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (we_i && addr_i == A_IEN) begin
            en_q <= wbits_i;
        end
    end

    assign state_o = state_q;
    assign en_o    = en_q;
    assign irq_o   = state_q & en_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R11: a completion always leaves its bit set, even against a clear.
        p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
            done_i[c] |=> state_q[c]);
        // R10: a written one without a completion clears the bit.
        p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (we_i && addr_i == A_ISTATE && wbits_i[c] && !done_i[c]) |=> !state_q[c]);
        // R10: a set bit survives any cycle without a written one.
        p_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q[c] && !(we_i && addr_i == A_ISTATE && wbits_i[c])) |=> state_q[c]);
    end

endmodule

// File: rtl/patt_seq.sv
// Module: patt_seq
// One pattern channel: a divider makes the channel clock, a bit counter
// steps through the pattern on each falling edge of the internal clock, and
// a repeat counter ends the run. The settings are copied in while disabled
// (and in the first enabled cycle) and held frozen while running.
// Assumes cfg_i is stable in the cycle the channel leaves idle.
module patt_seq
    import patt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_i,
    input  chan_cfg_t cfg_i,
    output logic      pcl_o,
    output logic      pda_o,
    output logic      done_o
);

    seq_state_e       state;
    chan_cfg_t        shadow;
    logic [DIV_W-1:0] div_cnt;
    logic [LEN_W-1:0] bit_cnt;
    logic [REP_W-1:0] rep_cnt;
    logic             clk_int;

    logic div_wrap, bit_last, rep_last, run_last;

    assign div_wrap = (div_cnt == shadow.prediv);
    assign bit_last = (bit_cnt == shadow.len);
    assign rep_last = (rep_cnt == shadow.reps);
    assign run_last = div_wrap && clk_int && bit_last && rep_last;

    // Sequencer: state, settings copy and the three nested counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SEQ_IDLE;
            shadow  <= '0;
            div_cnt <= '0;
            bit_cnt <= '0;
            rep_cnt <= '0;
            clk_int <= 1'b0;
        end else if (!en_i) begin
            state   <= SEQ_IDLE;
            shadow  <= cfg_i;
            div_cnt <= '0;
            bit_cnt <= '0;
            rep_cnt <= '0;
            clk_int <= 1'b0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    state  <= SEQ_RUN;
                    shadow <= cfg_i;
                end
                SEQ_RUN: begin
                    if (div_wrap) begin
                        div_cnt <= '0;
                        clk_int <= ~clk_int;
                        if (clk_int) begin
                            if (bit_last) begin
                                bit_cnt <= '0;
                                if (rep_last) begin
                                    state <= SEQ_END;
                                end else begin
                                    rep_cnt <= rep_cnt + 1'b1;
                                end
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                default: begin
                    state <= SEQ_END;
                end
            endcase
        end
    end

    assign pcl_o  = clk_int ^ shadow.pol;
    assign pda_o  = (state == SEQ_RUN) && shadow.pattern[bit_cnt];
    assign done_o = (state == SEQ_RUN) && run_last;

    // R3: the divider never passes its wrap value while running.
    p_div_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_RUN) |-> (div_cnt <= shadow.prediv));
    // R5: bit and repeat counters stay within the programmed fields.
    p_bit_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_RUN) |-> (bit_cnt <= shadow.len && rep_cnt <= shadow.reps));
    // R6: the settings copy is frozen while the channel runs.
    p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_RUN && en_i) |=> $stable(shadow));
    // R8: a completion pulse parks the channel with its clock back at idle.
    p_done_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && en_i) |=> (state == SEQ_END && !clk_int));

endmodule

// File: rtl/dual_pattern_ctrl.sv
// Module: dual_pattern_ctrl
// Top level of the dual-channel pattern controller: a register bank, one
// sequencer per channel and the completion interrupt logic. Enabling several
// channels in one control write starts them on the same cycle.
// Assumes a single-cycle register write port and a combinational read port.
module dual_pattern_ctrl
    import patt_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_we_i,
    input  logic [5:0]        reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic [1:0]        pcl_o,
    output logic [1:0]        pda_o,
    output logic [1:0]        irq_done_o
);

    chan_cfg_t [NUM_CH-1:0] cfg;
    logic [NUM_CH-1:0]      ch_en;
    logic [NUM_CH-1:0]      ch_done;
    logic [NUM_CH-1:0]      istate;
    logic [NUM_CH-1:0]      ien;

    patt_regs u_regs (
        .clk      (clk_i),
        .rst_n    (rst_ni),
        .we_i     (reg_we_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .istate_i (istate),
        .ien_i    (ien),
        .rdata_o  (reg_rdata_o),
        .en_o     (ch_en),
        .cfg_o    (cfg)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        patt_seq u_seq (
            .clk    (clk_i),
            .rst_n  (rst_ni),
            .en_i   (ch_en[c]),
            .cfg_i  (cfg[c]),
            .pcl_o  (pcl_o[c]),
            .pda_o  (pda_o[c]),
            .done_o (ch_done[c])
        );
    end

    patt_irq u_irq (
        .clk     (clk_i),
        .rst_n   (rst_ni),
        .we_i    (reg_we_i),
        .addr_i  (reg_addr_i),
        .wbits_i (reg_wdata_i[NUM_CH-1:0]),
        .done_i  (ch_done),
        .state_o (istate),
        .en_o    (ien),
        .irq_o   (irq_done_o)
    );

endmodule

// File: tb/dual_pattern_ctrl_test.sv
`timescale 1ns/1ps
module dual_pattern_ctrl_test;

    localparam int K_PCL = 0, K_PDA = 1, K_IRQ = 2;

    typedef struct {
        int    cyc;
        int    ch;
        int    kind;
        logic  val;
        string req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  pcl, pda, irq;

    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    int    wr_cyc = 0;
    item_t exp_q[$];

    dual_pattern_ctrl uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .pcl_o       (pcl),
        .pda_o       (pda),
        .irq_done_o  (irq)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_cyc = cyc + 1;
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic push(input int c, input int ch, input int kind, input logic v, input string req);
        item_t it;
        it.cyc = c; it.ch = ch; it.kind = kind; it.val = v; it.req = req;
        exp_q.push_back(it);
    endtask

    // Driver side of the scoreboard: one expected value per line per cycle.
    task automatic expect_run(input int c0, input int ch, input logic [63:0] pat,
                              input int len, input int reps, input int pdiv,
                              input bit pol, input bit ien_bit, input string tag);
        int h  = pdiv + 1;
        int tt = 2 * (len + 1) * (reps + 1) * h;
        push(c0, ch, K_PCL, pol, "R3");
        push(c0, ch, K_PDA, 1'b0, "R2");
        push(c0 + tt, ch, K_IRQ, 1'b0, "R8");
        for (int t = 0; t <= tt; t++) begin
            if (t < tt) begin
                push(c0 + 1 + t, ch, K_PCL, logic'(((t / h) % 2) == 1) ^ pol, "R3");
                push(c0 + 1 + t, ch, K_PDA, pat[(t / (2 * h)) % (len + 1)], (t == 0) ? "R2" : tag);
            end else begin
                push(c0 + 1 + t, ch, K_PCL, pol, "R5");
                push(c0 + 1 + t, ch, K_PDA, 1'b0, "R5");
                push(c0 + 1 + t, ch, K_IRQ, ien_bit, "R9");
            end
        end
    endtask

    // Monitor side: compare every item due in the current cycle.
    always @(negedge clk) begin
        for (int i = exp_q.size() - 1; i >= 0; i--) begin
            if (exp_q[i].cyc <= cyc) begin
                logic a;
                case (exp_q[i].kind)
                    K_PCL:   a = pcl[exp_q[i].ch];
                    K_PDA:   a = pda[exp_q[i].ch];
                    default: a = irq[exp_q[i].ch];
                endcase
                if (exp_q[i].cyc < cyc) check(1'b0, exp_q[i].req, 32'hdead, 32'(exp_q[i].cyc));
                else check(a === exp_q[i].val, exp_q[i].req, 32'(a), 32'(exp_q[i].val));
                exp_q.delete(i);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int c;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(6'h00, d); check(d == 0, "R1", d, 0);
        rd(6'h20, d); check(d == 0, "R1", d, 0);
        rd(6'h1C, d); check(d == 0, "R1", d, 0);
        check(pcl == 0 && pda == 0 && irq == 0, "R1", {pcl, pda, irq}, 0);

        // R12: readback through the map
        wr(6'h08, 32'hDEADBEEF); rd(6'h08, d); check(d == 32'hDEADBEEF, "R12", d, 32'hDEADBEEF);
        wr(6'h18, 32'h0000_00A5); rd(6'h18, d); check(d == 32'h0000_00A5, "R12", d, 32'hA5);
        wr(6'h24, 32'h3); rd(6'h24, d); check(d == 3, "R12", d, 3);

        // R2 R3 R4 R5 R8 R9: channel 0 alone, 4 bits x 2 passes, prediv 1
        wr(6'h0C, 32'h6); wr(6'h10, 32'h0); wr(6'h04, 32'h1);
        wr(6'h1C, 32'h3 | (32'h1 << 6)); wr(6'h24, 32'h1);
        wr(6'h00, 32'h1); c = wr_cyc;
        expect_run(c, 0, 64'h6, 3, 1, 1, 1'b0, 1'b1, "R4");
        push(c + 20, 1, K_PDA, 1'b0, "R2");
        wait_cyc(c + 36);
        rd(6'h20, d); check(d == 1, "R8", d, 1);
        check(irq == 2'b01, "R9", irq, 2'b01);
        wr(6'h24, 32'h0); #1 check(irq == 2'b00, "R9", irq, 0);
        wr(6'h20, 32'h2); rd(6'h20, d); check(d == 1, "R10", d, 1);
        wr(6'h20, 32'h1); rd(6'h20, d); check(d == 0, "R10", d, 0);
        wr(6'h00, 32'h0);

        // R2: halt mid-run; no completion follows
        wr(6'h0C, 32'hFFFF_FFFF); wr(6'h1C, 32'h7 | (32'h3 << 6));
        wr(6'h00, 32'h1); c = wr_cyc;
        wait_cyc(c + 6); check(pda[0] == 1'b1, "R2", pda[0], 1);
        wr(6'h00, 32'h0); c = wr_cyc;
        wait_cyc(c + 1); check(pda[0] == 1'b0 && pcl[0] == 1'b0, "R2", {pcl[0], pda[0]}, 0);
        wait_cyc(c + 150);
        rd(6'h20, d); check(d == 0, "R2", d, 0);
        check(pda[0] == 1'b0, "R2", pda[0], 0);

        // R4: channel 1, 40 bits reaching into the high word
        wr(6'h14, 32'h8000_0001); wr(6'h18, 32'h0000_00A5);
        wr(6'h1C, 32'd39 << 16); wr(6'h08, 32'h0); wr(6'h24, 32'h2);
        wr(6'h00, 32'h2); c = wr_cyc;
        expect_run(c, 1, {32'h0000_00A5, 32'h8000_0001}, 39, 0, 0, 1'b0, 1'b1, "R4");
        wait_cyc(c + 84);
        wr(6'h00, 32'h0); wr(6'h20, 32'h3);

        // R7: lockstep start of both channels, opposite polarity
        wr(6'h0C, 32'h3); wr(6'h10, 32'h0); wr(6'h14, 32'h5); wr(6'h18, 32'h0);
        wr(6'h1C, 32'h3 | (32'h3 << 16)); wr(6'h04, 32'h1); wr(6'h08, 32'h1);
        wr(6'h24, 32'h3); wr(6'h00, 32'h8);
        wr(6'h00, 32'hB); c = wr_cyc;
        expect_run(c, 0, 64'h3, 3, 0, 1, 1'b0, 1'b1, "R7");
        expect_run(c, 1, 64'h5, 3, 0, 1, 1'b1, 1'b1, "R7");
        wait_cyc(c + 20);
        rd(6'h20, d); check(d == 3, "R7", d, 3);
        wr(6'h00, 32'h0); wr(6'h20, 32'h3);

        // R6: reprogramming a running channel has no effect until re-enable
        wr(6'h0C, 32'h9); wr(6'h1C, 32'h3); wr(6'h04, 32'h2); wr(6'h24, 32'h1);
        wr(6'h00, 32'h1); c = wr_cyc;
        expect_run(c, 0, 64'h9, 3, 0, 2, 1'b0, 1'b1, "R6");
        wr(6'h0C, 32'hF0); wr(6'h1C, 32'h7); wr(6'h04, 32'h0); wr(6'h00, 32'h5);
        wait_cyc(c + 28);
        wr(6'h00, 32'h0); wr(6'h20, 32'h1);
        wr(6'h00, 32'h1); c = wr_cyc;
        expect_run(c, 0, 64'hF0, 7, 0, 0, 1'b0, 1'b1, "R6");
        wait_cyc(c + 20);
        wr(6'h00, 32'h0); wr(6'h20, 32'h1);

        // R11: clear lands on the completion edge; the set wins
        wr(6'h0C, 32'h1); wr(6'h1C, 32'h0); wr(6'h04, 32'h0);
        wr(6'h00, 32'h1); c = wr_cyc;
        expect_run(c, 0, 64'h1, 0, 0, 0, 1'b0, 1'b1, "R5");
        @(negedge clk);
        wr(6'h20, 32'h1);
        rd(6'h20, d); check(d[0] == 1'b1, "R11", d, 1);
        wr(6'h20, 32'h1); rd(6'h20, d); check(d == 0, "R10", d, 0);
        wr(6'h00, 32'h0);

        wait_cyc(cyc + 4);
        check(exp_q.size() == 0, "R5", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule